// File: doc/BRIEF.md
# Interprocessor Interrupt Dispatch Unit

This block lets two processors raise software interrupts at each other, or at themselves, through four shared channels. Each channel has a configuration register that holds a vector and a priority. A processor raises an interrupt by writing a destination bit mask to the channel's send register. Every processor whose bit is set in the mask then holds a pending event for that channel. The send register is one physical register that can be reached at two aliased addresses. It is write-triggered and reads back as zero.

Each processor has its own delivery port. The port presents the most urgent pending channel together with the vector and priority that were in force when that event was dispatched. The processor pulses its acknowledge line to retire the presented event. Arbitration against other interrupt sources is left to logic outside this block.

Register address layout: bits [1:0] select the channel, bit 2 selects the register kind (0 = vector/priority configuration, 1 = send), and bit 3 is an alias bit that is ignored. Configuration data layout: bits [7:0] hold the vector and bits [11:8] hold the priority. Send data layout: bit n is the destination bit for processor n.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, no processor has a request raised, and every configuration register reads back as zero.
- R2: A write to a configuration register stores the vector from data bits [7:0] and the priority from data bits [11:8]. A read of that address returns those fields in the same positions.
- R3: A send write sets a pending event on that channel for every processor whose mask bit is set. The processor's request output rises on the clock edge that captures the write.
- R4: A read of any send address returns zero.
- R5: Address bit 3 is ignored, so both aliases reach the same configuration register and the same send register.
- R6: A send write with an all-zero mask has no effect on any request.
- R7: Sending again on a channel that is already pending for a processor does not queue a second event: one acknowledge retires it.
- R8: An acknowledge retires only the event that the acknowledging processor is being presented. The other processor's events are untouched.
- R9: A processor is presented the pending channel with the highest priority value. On a tie, the lower channel number wins. The port outputs that channel's number, vector and priority.
- R10: A pending event keeps the vector and priority captured at dispatch. A later configuration write affects only events dispatched after it.
- R11: If a send write targets the same processor and channel that is being acknowledged in the same cycle, the event stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: alias, kind, channel |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address, same layout as wr_addr |
| rd_data | output | 16 | Read data, combinational |
| ack | input | 2 | Per-processor acknowledge pulse for the presented event |
| irq_req | output | 2 | Per-processor request |
| irq_vec | output | 16 | Per-processor presented vector, 8 bits each |
| irq_pri | output | 8 | Per-processor presented priority, 4 bits each |
| irq_chan | output | 4 | Per-processor presented channel, 2 bits each |

## Verification
The assertions take for granted that a processor pulses its acknowledge line only while its request is raised. The stimulus keeps to this: every acknowledge is issued after the bench has checked that the request is high. The assertions also assume that no register write arrives while the internally synchronised reset is still asserted. The bench therefore waits several cycles after releasing reset before it writes anything. Writes and acknowledges are held for exactly one clock edge, and at least one idle cycle separates them.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic {
    KIND_CFG  = 1'b0,
    KIND_SEND = 1'b1
  } reg_kind_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ipi_cfg_regs.sv
module ipi_cfg_regs #(
  parameter int NUM_CHAN = 4,
  parameter int VEC_W    = 8,
  parameter int PRI_W    = 4,
  parameter int DATA_W   = 16,
  parameter int CH_W     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CH_W-1:0]           cfg_chan,
  input  logic [VEC_W+PRI_W-1:0]    cfg_wdata,
  input  logic [CH_W-1:0]           rd_chan,
  input  logic                      rd_send,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_CHAN*VEC_W-1:0] vec_flat,
  output logic [NUM_CHAN*PRI_W-1:0] pri_flat
);
  logic [VEC_W-1:0] vec_arr [NUM_CHAN];
  logic [PRI_W-1:0] pri_arr [NUM_CHAN];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic             en;
    logic [VEC_W-1:0] vec_d, vec_q;
    logic [PRI_W-1:0] pri_d, pri_q;

    always_comb begin
      en    = cfg_we && (cfg_chan == CH_W'(c));
      vec_d = cfg_wdata[VEC_W-1:0];
      pri_d = cfg_wdata[VEC_W +: PRI_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q <= '0;
        pri_q <= '0;
      end else if (en) begin
        vec_q <= vec_d;
        pri_q <= pri_d;
      end
    end

    assign vec_arr[c]                  = vec_q;
    assign pri_arr[c]                  = pri_q;
    assign vec_flat[c*VEC_W +: VEC_W] = vec_q;
    assign pri_flat[c*PRI_W +: PRI_W] = pri_q;
  end

  always_comb begin
    if (rd_send) rd_data = '0;
    else         rd_data = DATA_W'({pri_arr[rd_chan], vec_arr[rd_chan]});
  end
endmodule

// File: rtl/ipi_pick.sv
module ipi_pick #(
  parameter int NUM_CHAN = 4,
  parameter int PRI_W    = 4,
  parameter int CH_W     = 2
) (
  input  logic [NUM_CHAN-1:0]       pend,
  input  logic [NUM_CHAN*PRI_W-1:0] pri_flat,
  output logic                      found,
  output logic [CH_W-1:0]           idx
);
  logic [PRI_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (pend[c] && (!found || (pri_flat[c*PRI_W +: PRI_W] > best))) begin
        found = 1'b1;
        idx   = CH_W'(c);
        best  = pri_flat[c*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/ipi_cpu_port.sv
module ipi_cpu_port #(
  parameter int NUM_CHAN = 4,
  parameter int VEC_W    = 8,
  parameter int PRI_W    = 4,
  parameter int CH_W     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      send_we,
  input  logic [CH_W-1:0]           send_chan,
  input  logic                      send_hit,
  input  logic [NUM_CHAN*VEC_W-1:0] cfg_vec_flat,
  input  logic [NUM_CHAN*PRI_W-1:0] cfg_pri_flat,
  input  logic                      ack,
  output logic                      req,
  output logic [VEC_W-1:0]          vec,
  output logic [PRI_W-1:0]          pri,
  output logic [CH_W-1:0]           chan
);
  logic [NUM_CHAN-1:0]       pend_q, pend_d;
  logic [NUM_CHAN*PRI_W-1:0] snap_pri_flat;
  logic [VEC_W-1:0]          snap_vec_arr [NUM_CHAN];
  logic [PRI_W-1:0]          snap_pri_arr [NUM_CHAN];
  logic                      found;
  logic [CH_W-1:0]           sel;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_slot
    logic             set_c, clr_c, snap_en;
    logic [VEC_W-1:0] sv_q;
    logic [PRI_W-1:0] sp_q;

    always_comb begin
      set_c     = send_we && send_hit && (send_chan == CH_W'(c));
      clr_c     = ack && found && (sel == CH_W'(c));
      pend_d[c] = set_c | (pend_q[c] & ~clr_c);
      snap_en   = set_c && (!pend_q[c] || clr_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sv_q <= '0;
        sp_q <= '0;
      end else if (snap_en) begin
        sv_q <= cfg_vec_flat[c*VEC_W +: VEC_W];
        sp_q <= cfg_pri_flat[c*PRI_W +: PRI_W];
      end
    end

    assign snap_vec_arr[c]                 = sv_q;
    assign snap_pri_arr[c]                 = sp_q;
    assign snap_pri_flat[c*PRI_W +: PRI_W] = sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  ipi_pick #(.NUM_CHAN(NUM_CHAN), .PRI_W(PRI_W), .CH_W(CH_W)) pick_i (
    .pend     (pend_q),
    .pri_flat (snap_pri_flat),
    .found    (found),
    .idx      (sel)
  );

  always_comb begin
    req  = found;
    chan = sel;
    vec  = found ? snap_vec_arr[sel] : '0;
    pri  = found ? snap_pri_arr[sel] : '0;
  end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int  NUM_CPU  = 2,
  parameter int  NUM_CHAN = 4,
  parameter int  VEC_W    = 8,
  parameter int  PRI_W    = 4,
  parameter int  DATA_W   = 16,
  localparam int CH_W     = ipi_pkg::idx_width(NUM_CHAN),
  localparam int ADDR_W   = CH_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  input  logic [NUM_CPU-1:0]       ack,
  output logic [NUM_CPU-1:0]       irq_req,
  output logic [NUM_CPU*VEC_W-1:0] irq_vec,
  output logic [NUM_CPU*PRI_W-1:0] irq_pri,
  output logic [NUM_CPU*CH_W-1:0]  irq_chan
);
  import ipi_pkg::*;

  logic [1:0]                rst_pipe;
  logic                      rst_int_n;
  reg_kind_e                 wr_kind, rd_kind;
  logic                      cfg_we, send_we, rd_send;
  logic [CH_W-1:0]           wr_chan;
  logic [NUM_CPU-1:0]        send_mask;
  logic [NUM_CHAN*VEC_W-1:0] cfg_vec_flat;
  logic [NUM_CHAN*PRI_W-1:0] cfg_pri_flat;
  logic                      unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    wr_kind   = reg_kind_e'(wr_addr[CH_W]);
    rd_kind   = reg_kind_e'(rd_addr[CH_W]);
    wr_chan   = wr_addr[CH_W-1:0];
    cfg_we    = wr_en && (wr_kind == KIND_CFG);
    send_we   = wr_en && (wr_kind == KIND_SEND);
    rd_send   = (rd_kind == KIND_SEND);
    send_mask = wr_data[NUM_CPU-1:0];
  end

  assign unused_bits = ^{wr_addr[ADDR_W-1], rd_addr[ADDR_W-1],
                         wr_data[DATA_W-1:VEC_W+PRI_W]};

  ipi_cfg_regs #(
    .NUM_CHAN(NUM_CHAN), .VEC_W(VEC_W), .PRI_W(PRI_W),
    .DATA_W(DATA_W), .CH_W(CH_W)
  ) cfg_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_chan  (wr_chan),
    .cfg_wdata (wr_data[VEC_W+PRI_W-1:0]),
    .rd_chan   (rd_addr[CH_W-1:0]),
    .rd_send   (rd_send),
    .rd_data   (rd_data),
    .vec_flat  (cfg_vec_flat),
    .pri_flat  (cfg_pri_flat)
  );

  for (genvar p = 0; p < NUM_CPU; p++) begin : g_cpu
    ipi_cpu_port #(
      .NUM_CHAN(NUM_CHAN), .VEC_W(VEC_W), .PRI_W(PRI_W), .CH_W(CH_W)
    ) port_i (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .send_we      (send_we),
      .send_chan    (wr_chan),
      .send_hit     (send_mask[p]),
      .cfg_vec_flat (cfg_vec_flat),
      .cfg_pri_flat (cfg_pri_flat),
      .ack          (ack[p]),
      .req          (irq_req[p]),
      .vec          (irq_vec[p*VEC_W +: VEC_W]),
      .pri          (irq_pri[p*PRI_W +: PRI_W]),
      .chan         (irq_chan[p*CH_W +: CH_W])
    );
  end
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int NUM_CPU = 2,
  parameter int VEC_W   = 8,
  parameter int DATA_W  = 16
) (
  input logic                     clk,
  input logic                     rst_ni,
  input logic                     send_we,
  input logic [NUM_CPU-1:0]       send_mask,
  input logic [NUM_CPU-1:0]       ack,
  input logic [NUM_CPU-1:0]       irq_req,
  input logic [NUM_CPU*VEC_W-1:0] irq_vec,
  input logic                     rd_send,
  input logic [DATA_W-1:0]        rd_data
);
  p_send_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_send |-> (rd_data == '0));

  p_zero_mask_inert_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (send_we && (send_mask == '0) && (ack == '0)) |=> $stable(irq_req));

  for (genvar p = 0; p < NUM_CPU; p++) begin : g_p
    p_send_raises_r3: assert property (@(posedge clk) disable iff (!rst_ni)
      (send_we && send_mask[p]) |=> irq_req[p]);

    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_ni)
      (irq_req[p] && !ack[p]) |=> irq_req[p]);

    p_vec_frozen_r10: assert property (@(posedge clk) disable iff (!rst_ni)
      (irq_req[p] && !ack[p] && !send_we) |=> $stable(irq_vec[p*VEC_W +: VEC_W]));
  end
endmodule

bind ipi_dispatch ipi_dispatch_chk #(
  .NUM_CPU(NUM_CPU), .VEC_W(VEC_W), .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rst_ni    (rst_int_n),
  .send_we   (send_we),
  .send_mask (send_mask),
  .ack       (ack),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec),
  .rd_send   (rd_send),
  .rd_data   (rd_data)
);

// File: tb/ipi_dispatch_tb_top.sv
module ipi_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  rd_addr;
  logic [15:0] rd_data;
  logic [1:0]  ack;
  logic [1:0]  irq_req;
  logic [15:0] irq_vec;
  logic [7:0]  irq_pri;
  logic [3:0]  irq_chan;

  int n_tests;
  int n_fail;
  bit done;

  ipi_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_pri(irq_pri), .irq_chan(irq_chan)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] a_cfg(input int ch, input bit alias_b);
    return {alias_b, 1'b0, 2'(ch)};
  endfunction
  function automatic logic [3:0] a_send(input int ch, input bit alias_b);
    return {alias_b, 1'b1, 2'(ch)};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] a,
                      input logic [15:0] d, input logic [1:0] ak);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; ack = ak;
    @(negedge clk);
    wr_en = 1'b0; ack = 2'b00;
  endtask

  task automatic set_cfg(input int ch, input int pri, input int vec);
    step(1'b1, a_cfg(ch, 1'b0), 16'({4'(pri), 8'(vec)}), 2'b00);
  endtask

  task automatic read_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    check(req, "rd_data", 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset;
    check("R1", "irq_req", 32'(irq_req), 0);
    for (int c = 0; c < 4; c++) read_chk("R1", a_cfg(c, 1'b0), 16'h0);
  endtask

  task automatic t_cfg;
    for (int c = 0; c < 4; c++) set_cfg(c, c + 1, 8'h40 + c);
    for (int c = 0; c < 4; c++) begin
      read_chk("R2", a_cfg(c, 1'b0), 16'({4'(c + 1), 8'(8'h40 + c)}));
      read_chk("R5", a_cfg(c, 1'b1), 16'({4'(c + 1), 8'(8'h40 + c)}));
    end
    step(1'b1, a_cfg(3, 1'b1), 16'h0A77, 2'b00);
    read_chk("R5", a_cfg(3, 1'b0), 16'h0A77);
    set_cfg(3, 4, 8'h43);
  endtask

  task automatic t_fanout;
    step(1'b1, a_send(1, 1'b0), 16'h0002, 2'b00);
    check("R3", "irq_req", 32'(irq_req), 32'h2);
    check("R3", "cpu1 vec", 32'(irq_vec[15:8]), 32'h41);
    check("R3", "cpu1 pri", 32'(irq_pri[7:4]), 32'h2);
    check("R3", "cpu1 chan", 32'(irq_chan[3:2]), 32'h1);
    read_chk("R4", a_send(1, 1'b0), 16'h0);
    read_chk("R4", a_send(1, 1'b1), 16'h0);
    step(1'b0, 4'h0, 16'h0, 2'b10);
    check("R8", "irq_req after ack", 32'(irq_req), 32'h0);
  endtask

  task automatic t_self;
    step(1'b1, a_send(2, 1'b1), 16'h0003, 2'b00);
    check("R5", "irq_req via alias", 32'(irq_req), 32'h3);
    check("R3", "cpu0 vec", 32'(irq_vec[7:0]), 32'h42);
    check("R3", "cpu1 vec", 32'(irq_vec[15:8]), 32'h42);
    step(1'b0, 4'h0, 16'h0, 2'b01);
    check("R8", "only cpu0 cleared", 32'(irq_req), 32'h2);
    step(1'b0, 4'h0, 16'h0, 2'b10);
    check("R8", "both cleared", 32'(irq_req), 32'h0);
  endtask

  task automatic t_zero;
    step(1'b1, a_send(0, 1'b0), 16'h0000, 2'b00);
    check("R6", "irq_req zero mask", 32'(irq_req), 32'h0);
    step(1'b1, a_send(0, 1'b0), 16'h0001, 2'b00);
    step(1'b1, a_send(3, 1'b0), 16'h0000, 2'b00);
    check("R6", "chan after zero mask", 32'(irq_chan[1:0]), 32'h0);
    step(1'b0, 4'h0, 16'h0, 2'b01);
    check("R6", "cleared", 32'(irq_req), 32'h0);
  endtask

  task automatic t_repeat;
    step(1'b1, a_send(3, 1'b0), 16'h0001, 2'b00);
    step(1'b1, a_send(3, 1'b1), 16'h0001, 2'b00);
    check("R7", "pending", 32'(irq_req), 32'h1);
    step(1'b0, 4'h0, 16'h0, 2'b01);
    check("R7", "single ack retires", 32'(irq_req), 32'h0);
  endtask

  task automatic t_pick;
    set_cfg(0, 5, 8'h50);
    set_cfg(1, 9, 8'h51);
    set_cfg(2, 9, 8'h52);
    set_cfg(3, 2, 8'h53);
    for (int c = 3; c >= 0; c--) step(1'b1, a_send(c, 1'b0), 16'h0001, 2'b00);
    check("R9", "first chan", 32'(irq_chan[1:0]), 32'h1);
    check("R9", "first pri", 32'(irq_pri[3:0]), 32'h9);
    check("R9", "first vec", 32'(irq_vec[7:0]), 32'h51);
    step(1'b0, 4'h0, 16'h0, 2'b01);
    check("R9", "second chan", 32'(irq_chan[1:0]), 32'h2);
    step(1'b0, 4'h0, 16'h0, 2'b01);
    check("R9", "third chan", 32'(irq_chan[1:0]), 32'h0);
    check("R9", "third vec", 32'(irq_vec[7:0]), 32'h50);
    step(1'b0, 4'h0, 16'h0, 2'b01);
    check("R9", "fourth chan", 32'(irq_chan[1:0]), 32'h3);
    step(1'b0, 4'h0, 16'h0, 2'b01);
    check("R9", "drained", 32'(irq_req), 32'h0);
  endtask

  task automatic t_snapshot;
    set_cfg(1, 3, 8'h61);
    step(1'b1, a_send(1, 1'b0), 16'h0001, 2'b00);
    set_cfg(1, 7, 8'h71);
    check("R10", "old vec kept", 32'(irq_vec[7:0]), 32'h61);
    check("R10", "old pri kept", 32'(irq_pri[3:0]), 32'h3);
    step(1'b0, 4'h0, 16'h0, 2'b01);
    step(1'b1, a_send(1, 1'b0), 16'h0001, 2'b00);
    check("R10", "new vec used", 32'(irq_vec[7:0]), 32'h71);
    step(1'b0, 4'h0, 16'h0, 2'b01);
  endtask

  task automatic t_collide;
    step(1'b1, a_send(0, 1'b0), 16'h0001, 2'b00);
    step(1'b1, a_send(0, 1'b0), 16'h0001, 2'b01);
    check("R11", "pending kept", 32'(irq_req), 32'h1);
    step(1'b0, 4'h0, 16'h0, 2'b01);
    check("R11", "retired", 32'(irq_req), 32'h0);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg();
    t_fanout();
    t_self();
    t_zero();
    t_repeat();
    t_pick();
    t_snapshot();
    t_collide();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule